// File: doc/BRIEF.md
# LIN Break Generator, Break Detector and Serial Pin Override

This block sits beside a UART-style serial port and adds the extended line-control features needed for LIN operation. On request it holds the transmit line low for a programmable number of bit times (13 to 16) to send a LIN break. It watches the receive line on every bit-clock enable and latches a sticky flag when the line has been low long enough to count as a break. That flag can drive an interrupt output.

Software reaches the block through one 16-bit register word whose upper byte holds the controls. Besides the break length, the flag and the interrupt enable, the byte lets software take over the transmit pin and drive it to a fixed level. It also returns the live receive pin level. Two further bits, a sampling-edge select and a continuous-clock enable for synchronous operation, are only stored and read back here. The framing logic supplies the normal transmit bit on `txData` and a bit-rate strobe on `bitTick`.

Top module: `lin_break_pin_ctrl`

## Requirements
- R1: After reset, the register word reads `{5'b00000, rxPin, 10'b0}`: interrupt enable, flag, length code, override enable and both synchronous-mode bits are 0. The stored override level is 1.
- R2: The break-length code sits in bits 13:12 (bit 12 is its low bit). Codes 0, 1, 2 and 3 make an accepted break hold `txPin` low for exactly 13, 14, 15 and 16 `bitTick` pulses after the request.
- R3: The break flag (bit 14) sets in the cycle after the 11th consecutive `bitTick` that samples `rxPin` low. A `bitTick` that samples `rxPin` high restarts the count. The flag sets only once per low period and re-arms after a high sample.
- R4: A register write with bit 14 = 0 clears the flag, and a write with bit 14 = 1 leaves it unchanged. If a detection and a clearing write fall in the same cycle, the flag ends up set.
- R5: `irq` is 1 exactly while the interrupt enable (bit 15) and the flag (bit 14) are both 1.
- R6: While the override enable (bit 11) is 1, `txPin` equals the last value written to bit 10. While it is 0, `txPin` is 0 during a break and equals `txData` otherwise.
- R7: Bit 10 of `regRdData` always shows the current level of `rxPin`, never the stored override level.
- R8: Bits 9 and 8 (continuous-clock enable, sampling-edge select) read back as last written. Bits 7:0 always read 0, whatever was written to them.
- R9: `brkBusy` goes to 1 in the cycle after a `brkReq` accepted while idle, and stays 1 until the last break bit time has been counted. A `brkReq` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | One-cycle bit-clock enable, one per bit time |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data (bits 15:8 used) |
| regRdData | output | 16 | Register read data |
| rxPin | input | 1 | Receive line level |
| txData | input | 1 | Normal serial transmit bit from the framer |
| txPin | output | 1 | Transmit line |
| brkReq | input | 1 | Request to transmit a LIN break |
| brkBusy | output | 1 | Break transmission in progress |
| irq | output | 1 | Break-detected interrupt |

## Verification
Each of the four length codes is used for a transmitted break. Idle cycles of random length are placed between bit ticks, and a second request is injected mid-break. This separates counting bit ticks from counting clocks, and an ignored request from a restarted one. The receive line is driven with runs of exactly 10 lows, 11 lows, a 10-low run broken by one high sample, and a long low period that is cleared while still low. Together these show the threshold, the count restart, and the once-per-period rule. Random register writes with random receive levels check read-back, the live bit 10 and the zero lower byte against a bench model. Directed cases cover override levels, the interrupt gate and a clear that coincides with detection.

// File: rtl/lbp_pkg.sv
package lbp_pkg;
  // register field positions inside the 16-bit access word
  localparam int unsigned POS_SFALL = 8;
  localparam int unsigned POS_CCLK  = 9;
  localparam int unsigned POS_PIN   = 10;
  localparam int unsigned POS_OVREN = 11;
  localparam int unsigned POS_LENLO = 12;
  localparam int unsigned POS_FLAG  = 14;
  localparam int unsigned POS_IE    = 15;

  // strobes from control to datapath
  typedef struct packed {
    logic setFlag;  // break detected this cycle
    logic brkLow;   // break transmission active
  } lbpStrobe_t;
endpackage

// File: rtl/lbp_control.sv
module lbp_control
  import lbp_pkg::*;
#(
  parameter int unsigned DETECT_LEN = 11,
  parameter int unsigned BREAK_BASE = 13,
  parameter int unsigned LEN_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bitTick,
  input  logic             rxPin,
  input  logic             brkReq,
  input  logic [LEN_W-1:0] brkLenCode,
  output lbpStrobe_t       strobe
);
  localparam int unsigned DET_W   = $clog2(DETECT_LEN + 1);
  localparam int unsigned MAX_BRK = BREAK_BASE + (1 << LEN_W) - 1;
  localparam int unsigned BRK_W   = $clog2(MAX_BRK + 1);
  localparam logic [DET_W-1:0] DET_LAST = DET_W'(DETECT_LEN - 1);
  localparam logic [DET_W-1:0] DET_FULL = DET_W'(DETECT_LEN);
  localparam logic [BRK_W-1:0] BRK_ONE  = BRK_W'(1);

  logic [DET_W-1:0] lowCnt;
  logic             detectHit;
  logic [BRK_W-1:0] brkCnt;
  logic             busy;

  // receive-side break detector: counts low samples, saturates after a hit
  assign detectHit = bitTick && !rxPin && (lowCnt == DET_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowCnt <= '0;
    end else if (bitTick) begin
      if (rxPin) begin
        lowCnt <= '0;
      end else if (lowCnt != DET_FULL) begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  // transmit-side break timer: length captured when the request is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      brkCnt <= '0;
    end else if (!busy) begin
      if (brkReq) begin
        busy   <= 1'b1;
        brkCnt <= BRK_W'(BREAK_BASE) + BRK_W'(brkLenCode);
      end
    end else if (bitTick) begin
      if (brkCnt == BRK_ONE) begin
        busy <= 1'b0;
      end
      brkCnt <= brkCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.setFlag = detectHit;
    strobe.brkLow  = busy;
  end
endmodule

// File: rtl/lbp_datapath.sv
module lbp_datapath
  import lbp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              rxPin,
  input  logic              txData,
  input  lbpStrobe_t        strobe,
  output logic [LEN_W-1:0]  brkLenCode,
  output logic              txPin,
  output logic              irq
);
  logic ieBit;
  logic flagBit;
  logic ovrEn;
  logic ovrVal;
  logic contClk;
  logic sampleFall;
  logic [LEN_W-1:0] lenCode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ieBit      <= 1'b0;
      lenCode    <= '0;
      ovrEn      <= 1'b0;
      ovrVal     <= 1'b1;
      contClk    <= 1'b0;
      sampleFall <= 1'b0;
    end else if (regWrEn) begin
      ieBit      <= regWrData[POS_IE];
      lenCode    <= regWrData[POS_LENLO +: LEN_W];
      ovrEn      <= regWrData[POS_OVREN];
      ovrVal     <= regWrData[POS_PIN];
      contClk    <= regWrData[POS_CCLK];
      sampleFall <= regWrData[POS_SFALL];
    end
  end

  // sticky flag: detection beats a same-cycle clear, writing 1 does nothing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagBit <= 1'b0;
    end else if (strobe.setFlag) begin
      flagBit <= 1'b1;
    end else if (regWrEn && !regWrData[POS_FLAG]) begin
      flagBit <= 1'b0;
    end
  end

  always_comb begin
    regRdData                      = '0;
    regRdData[POS_IE]              = ieBit;
    regRdData[POS_FLAG]            = flagBit;
    regRdData[POS_LENLO +: LEN_W]  = lenCode;
    regRdData[POS_OVREN]           = ovrEn;
    regRdData[POS_PIN]             = rxPin;
    regRdData[POS_CCLK]            = contClk;
    regRdData[POS_SFALL]           = sampleFall;
  end

  always_comb begin
    if (ovrEn)             txPin = ovrVal;
    else if (strobe.brkLow) txPin = 1'b0;
    else                   txPin = txData;
  end

  assign irq        = ieBit & flagBit;
  assign brkLenCode = lenCode;
endmodule

// File: rtl/lin_break_pin_ctrl.sv
module lin_break_pin_ctrl
  import lbp_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned LEN_W      = 2,
  parameter int unsigned DETECT_LEN = 11,
  parameter int unsigned BREAK_BASE = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bitTick,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              rxPin,
  input  logic              txData,
  output logic              txPin,
  input  logic              brkReq,
  output logic              brkBusy,
  output logic              irq
);
  lbpStrobe_t       strobe;
  logic [LEN_W-1:0] lenCode;

  lbp_control #(
    .DETECT_LEN(DETECT_LEN),
    .BREAK_BASE(BREAK_BASE),
    .LEN_W     (LEN_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bitTick   (bitTick),
    .rxPin     (rxPin),
    .brkReq    (brkReq),
    .brkLenCode(lenCode),
    .strobe    (strobe)
  );

  lbp_datapath #(
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .rxPin     (rxPin),
    .txData    (txData),
    .strobe    (strobe),
    .brkLenCode(lenCode),
    .txPin     (txPin),
    .irq       (irq)
  );

  assign brkBusy = strobe.brkLow;
endmodule

// File: rtl/lbp_checker.sv
module lbp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bitTick,
  input logic        regWrEn,
  input logic [15:0] regWrData,
  input logic [15:0] regRdData,
  input logic        rxPin,
  input logic        txPin,
  input logic        brkReq,
  input logic        brkBusy,
  input logic        irq
);
  // R5: interrupt follows enable and flag as seen at the register port
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (regRdData[15] && regRdData[14]));

  // R4: a set flag survives anything but a clearing write
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdData[14] && !(regWrEn && !regWrData[14])) |=> regRdData[14]);

  // R4: a clearing write with the line high leaves the flag at 0
  p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && !regWrData[14] && rxPin) |=> !regRdData[14]);

  // R9: the line is low during a break unless overridden
  p_busy_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brkBusy && !regRdData[11]) |-> !txPin);

  // R9: a break never ends without a bit tick, requests cannot cut it short
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brkBusy && !bitTick) |=> brkBusy);

  // R9: an idle request starts a break
  p_req_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!brkBusy && brkReq) |=> brkBusy);

  // R7: bit 10 reads the live receive level
  p_rx_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    regRdData[10] == rxPin);

  // R8: lower byte is always zero
  p_low_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    regRdData[7:0] == 8'h00);
endmodule

bind lin_break_pin_ctrl lbp_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bitTick  (bitTick),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .rxPin    (rxPin),
  .txPin    (txPin),
  .brkReq   (brkReq),
  .brkBusy  (brkBusy),
  .irq      (irq)
);

// File: tb/lin_break_pin_ctrl_tb.sv
module lin_break_pin_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bitTick = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        rxPin = 1'b1;
  logic        txData = 1'b1;
  logic        txPin;
  logic        brkReq = 1'b0;
  logic        brkBusy;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model of the stored fields
  logic       mIe = 0, mFlag = 0, mOe = 0, mOv = 1, mCc = 0, mSf = 0;
  logic [1:0] mLen = 0;

  always #2 clk = ~clk;  // 250 MHz

  lin_break_pin_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bitTick(bitTick), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .rxPin(rxPin),
    .txData(txData), .txPin(txPin), .brkReq(brkReq), .brkBusy(brkBusy),
    .irq(irq)
  );

  function automatic logic [15:0] expRead(input logic rx);
    return {mIe, mFlag, mLen, mOe, rx, mCc, mSf, 8'h00};
  endfunction

  function automatic logic expTx(input logic busy, input logic d);
    if (mOe) return mOv;
    if (busy) return 1'b0;
    return d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock with given tick; outputs settled on return
  task automatic step(input logic t);
    bitTick = t;
    @(negedge clk);
    bitTick = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    mIe = d[15];
    if (!d[14]) mFlag = 1'b0;
    mLen = d[13:12];
    mOe = d[11];
    mOv = d[10];
    mCc = d[9];
    mSf = d[8];
  endtask

  task automatic lowRun(input int n);
    rxPin = 1'b0;
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R7 live pin
    chk("R1 reset read", regRdData, 16'h0400);
    chk("R1 irq", irq, 0);
    chk("R1 busy", brkBusy, 0);
    rxPin = 1'b0; #1;
    chk("R7 rx low live", regRdData, 16'h0000);
    rxPin = 1'b1; #1;
    chk("R7 rx high live", regRdData, 16'h0400);

    // R8 sync bits and zero low byte
    wr(16'h03FF);
    chk("R8 readback", regRdData, expRead(1'b1));

    // R2, R9 break length for every code, random idle gaps, mid-break request
    txData = 1'b1;
    for (int code = 0; code < 4; code++) begin
      int n;
      wr(16'(code) << 12);
      brkReq = 1'b1; @(negedge clk); brkReq = 1'b0;
      chk("R9 busy after request", brkBusy, 1);
      chk("R2 tx low at start", txPin, 0);
      n = 0;
      while (brkBusy && n < 40) begin
        repeat ($urandom_range(0, 3)) step(1'b0);
        if (n == 3) brkReq = 1'b1;
        step(1'b1);
        brkReq = 1'b0;
        n++;
        if (brkBusy) chk("R2 tx held low", txPin, 0);
      end
      chk("R2 break length", n, 13 + code);
      chk("R9 released", brkBusy, 0);
      chk("R6 tx back to data", txPin, 1);
    end

    // R3 threshold: 10 lows no flag, 11th sets
    wr(16'h0000);
    rxPin = 1'b1; step(1'b1);
    lowRun(10);
    chk("R3 ten lows", regRdData[14], 0);
    step(1'b1);
    chk("R3 eleventh low", regRdData[14], 1);
    mFlag = 1'b1;
    // R4 write one ignored
    wr(16'h4000);
    chk("R4 write one keeps", regRdData[14], 1);
    // R5 irq gate
    chk("R5 ie off", irq, 0);
    wr(16'hC000);
    chk("R5 ie and flag", irq, 1);
    // R4 clear; R3 once per low period
    wr(16'h8000);
    chk("R4 cleared", regRdData[14], 0);
    chk("R5 flag off", irq, 0);
    lowRun(20);
    chk("R3 once per period", regRdData[14], 0);
    // re-arm
    rxPin = 1'b1; step(1'b1);
    lowRun(11);
    chk("R3 re-armed", regRdData[14], 1);
    mFlag = 1'b1;
    wr(16'h0000);
    // glitch restarts count
    rxPin = 1'b1; step(1'b1);
    lowRun(10);
    rxPin = 1'b1; step(1'b1);
    lowRun(10);
    chk("R3 high sample restarts", regRdData[14], 0);
    // R4 set wins over same-cycle clear (11th low here)
    regWrEn = 1'b1; regWrData = 16'h0000; bitTick = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; bitTick = 1'b0;
    chk("R4 set beats clear", regRdData[14], 1);
    mFlag = 1'b1;
    rxPin = 1'b1;
    wr(16'h0000);

    // R6 override
    txData = 1'b1;
    wr(16'h0800);
    chk("R6 forced zero", txPin, 0);
    txData = 1'b0; #1;
    wr(16'h0C00);
    chk("R6 forced one", txPin, 1);
    brkReq = 1'b1; @(negedge clk); brkReq = 1'b0;
    chk("R6 override during break", txPin, 1);
    for (int i = 0; i < 13; i++) step(1'b1);
    chk("R9 break done", brkBusy, 0);

    // constrained random register traffic, no ticks, flag bit kept 1
    for (int i = 0; i < 120; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      d[14] = 1'b1;
      rxPin = 1'($urandom);
      txData = 1'($urandom);
      wr(d);
      chk("R8 random readback", regRdData, expRead(rxPin));
      chk("R6 random tx", txPin, expTx(1'b0, txData));
      chk("R5 random irq", irq, mIe & mFlag);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule